// File: doc/BRIEF.md
# Stream FIFO with Release Gating

This block is a single-clock FIFO that sits between a packet payload receiver and a pixel output stage. The write side takes payload words tagged with start-of-packet and end-of-packet flags. A separate strobe reports, once per packet, whether that packet's CRC passed. The read side is a valid/ready stream that carries each word together with its packet flags.

A two-bit mode input decides when stored words become visible to the reader. In line mode, a packet is held until its CRC verdict arrives. A passing packet is released as a whole, and a failing one is erased by moving the write pointer back to where the packet began. In fill mode, words are held until the FIFO holds a programmable number of them, or until a packet end or a full FIFO forces the release. After that the reader drains the FIFO to empty. In short mode, words are readable one cycle after they are written.

The active mode is sampled from the input only when the FIFO is empty, no packet is open and nothing is being written. A reconfiguration therefore never splits a packet.

Top module: `stream_gate_fifo`

## Requirements
- R1: The mode input is decoded as 2'b00 line mode, 2'b01 fill mode, and 2'b10 or 2'b11 short mode. A new value is adopted only in a cycle where the FIFO is empty, no packet is open (an accepted start flag has not yet been followed by an accepted end flag), no packet is being dropped and no word is written. While a packet is open, a change on the mode input has no effect on the read side.
- R2: In line mode, rd_valid stays low for every word of a packet until a passing CRC strobe arrives. The packet becomes readable in the cycle after that strobe.
- R3: In line mode, a failing CRC strobe discards every word of the current packet. None of those words reaches the read side, and the next packet's words are read in their place.
- R4: In fill mode, rd_valid stays low while the occupancy is below the fill level. It rises in the cycle after the write that brings the occupancy to the fill level, or to full capacity.
- R5: In fill mode, accepting a word with the end flag set releases the held data even when the occupancy is below the fill level.
- R6: In fill mode, once data is released it stays readable until the FIFO is empty, even if the occupancy drops below the fill level. After the FIFO empties, new data is held again.
- R7: In short mode, a written word is readable in the next cycle, and CRC strobes have no effect on the stored data.
- R8: The fill level is ignored in line mode and in short mode.
- R9: wr_ready is low while the FIFO holds DEPTH words and no packet is being dropped. No word is lost or reordered under backpressure.
- R10: In line mode, when a single open packet fills the whole FIFO and one more word is offered, ovf_err is set and stays set until reset. The packet's stored words are discarded, and the remaining words are accepted and thrown away until that packet's CRC strobe. The next packet is then handled normally.
- R11: rd_sop and rd_eop come out with the word they were written with, and rd_valid stays high until the word is taken.
- R12: After reset, rd_valid is low, wr_ready is high and ovf_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Release mode request |
| cfg_fill_level | input | FILL_W | Occupancy threshold for fill mode |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word accepted this cycle |
| wr_data | input | DATA_W | Payload word |
| wr_sop | input | 1 | First word of a packet |
| wr_eop | input | 1 | Last word of a packet |
| crc_valid | input | 1 | CRC verdict strobe for the last packet |
| crc_pass | input | 1 | CRC verdict, 1 = pass |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | DATA_W | Read payload word |
| rd_sop | output | 1 | Read word starts a packet |
| rd_eop | output | 1 | Read word ends a packet |
| ovf_err | output | 1 | Sticky line-mode packet overflow flag |

## Verification
A wrong commit or rewind pointer shows up at the read side in the cycle after the CRC strobe. Either rd_valid stays low after a pass, or words from a failed packet appear in place of the next packet's first word. A stuck or early release flag in fill mode is visible one cycle after the threshold write, or right after the FIFO drains, as rd_valid at the wrong level. A stale mode register lets an open packet be read out early, and pointer faults break word order or wr_ready at the sixteenth write.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
  typedef enum logic [1:0] {
    MODE_LINE  = 2'b00,
    MODE_FILL  = 2'b01,
    MODE_SHORT = 2'b10
  } mode_e;

  function automatic mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'b00:   return MODE_LINE;
      2'b01:   return MODE_FILL;
      default: return MODE_SHORT;
    endcase
  endfunction
endpackage

// File: rtl/sgf_store.sv
module sgf_store #(
  parameter int W  = 18,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sgf_wctl.sv
module sgf_wctl
  import sgf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode_q,
  input  logic          wr_valid,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          crc_valid,
  input  logic          crc_pass,
  input  logic [AW:0]   rd_ptr_q,
  output logic          wr_ready,
  output logic          store_en,
  output logic [AW-1:0] store_addr,
  output logic [AW:0]   wr_ptr_q,
  output logic [AW:0]   wr_ptr_d,
  output logic [AW:0]   commit_q,
  output logic          in_pkt_q,
  output logic          drop_q,
  output logic          ovf_err
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [AW:0] occ, pending, base, commit_d;
  logic        full, line, ovf_hit, wr_fire;
  logic        drop_d, err_d, in_pkt_d;

  assign line     = (mode_q == MODE_LINE);
  assign occ      = wr_ptr_q - rd_ptr_q;
  assign pending  = wr_ptr_q - commit_q;
  assign full     = (occ == FULL_CNT);
  assign ovf_hit  = line && !drop_q && wr_valid && full && (pending == FULL_CNT);
  assign wr_ready = drop_q || !full;
  assign wr_fire  = wr_valid && wr_ready;
  // during a drop every word is discarded; the CRC strobe cycle already belongs to the next packet
  assign store_en = wr_fire && (!drop_q || crc_valid);

  always_comb begin
    base     = wr_ptr_q;
    commit_d = commit_q;
    drop_d   = drop_q;
    err_d    = ovf_err;
    in_pkt_d = in_pkt_q;
    if (line) begin
      if (crc_valid && !drop_q) begin
        if (crc_pass) commit_d = wr_ptr_q;
        else          base     = commit_q;
      end
      if (ovf_hit) begin
        base   = commit_q;
        drop_d = 1'b1;
        err_d  = 1'b1;
      end
      if (drop_q && crc_valid) drop_d = 1'b0;
    end
    wr_ptr_d = base + {{AW{1'b0}}, store_en};
    if (!line) commit_d = wr_ptr_d;
    if (wr_fire) begin
      if (wr_eop)      in_pkt_d = 1'b0;
      else if (wr_sop) in_pkt_d = 1'b1;
    end
  end

  assign store_addr = base[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      commit_q <= '0;
      drop_q   <= 1'b0;
      ovf_err  <= 1'b0;
      in_pkt_q <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      commit_q <= commit_d;
      drop_q   <= drop_d;
      ovf_err  <= err_d;
      in_pkt_q <= in_pkt_d;
    end
  end

  a_r9_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_q - rd_ptr_q) <= FULL_CNT);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r2_commit_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (line && $past(line) && (commit_q != $past(commit_q)))
      |-> $past(crc_valid && crc_pass && !drop_q));

  a_r3_fail_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (line && crc_valid && !crc_pass && !drop_q && !wr_valid) |=> (wr_ptr_q == commit_q));
endmodule

// File: rtl/sgf_rctl.sv
module sgf_rctl
  import sgf_pkg::*;
#(
  parameter int AW     = 4,
  parameter int FILL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [FILL_W-1:0] cfg_fill_level,
  input  logic [AW:0]       wr_ptr_q,
  input  logic [AW:0]       wr_ptr_d,
  input  logic [AW:0]       commit_q,
  input  logic              store_en,
  input  logic              wr_eop,
  input  logic              in_pkt_q,
  input  logic              drop_q,
  input  logic              rd_ready,
  output mode_e             mode_q,
  output logic              rd_valid,
  output logic [AW:0]       rd_ptr_q
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];
  localparam int CW = (FILL_W > AW + 1) ? FILL_W : AW + 1;

  logic        rd_fire, rel_q, rel_d, sw_ok;
  logic [AW:0] rd_ptr_d, cnt_next;
  logic [CW-1:0] cnt_ext, lvl_ext;
  mode_e       mode_d;

  assign rd_valid = (rd_ptr_q != commit_q) && ((mode_q != MODE_FILL) || rel_q);
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_ptr_d = rd_ptr_q + {{AW{1'b0}}, rd_fire};
  assign cnt_next = wr_ptr_d - rd_ptr_d;
  assign cnt_ext  = CW'(cnt_next);
  assign lvl_ext  = CW'(cfg_fill_level);

  always_comb begin
    if (cnt_next == '0)
      rel_d = 1'b0;
    else if (rel_q || (store_en && wr_eop) || (cnt_ext >= lvl_ext) || (cnt_next == FULL_CNT))
      rel_d = 1'b1;
    else
      rel_d = 1'b0;
  end

  assign sw_ok  = !in_pkt_q && !drop_q && (wr_ptr_q == rd_ptr_q) && !store_en;
  assign mode_d = sw_ok ? decode_mode(cfg_mode) : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      rel_q    <= 1'b0;
      mode_q   <= MODE_SHORT;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      rel_q    <= rel_d;
      mode_q   <= mode_d;
    end
  end

  a_r11_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  a_r1_switch_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past((wr_ptr_q == rd_ptr_q) && !in_pkt_q));
endmodule

// File: rtl/stream_gate_fifo.sv
module stream_gate_fifo
  import sgf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 4,
  parameter int FILL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [FILL_W-1:0] cfg_fill_level,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              crc_valid,
  input  logic              crc_pass,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop,
  output logic              ovf_err
);
  localparam int WW = DATA_W + 2;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          store_en, in_pkt_q, drop_q;
  logic [AW-1:0] store_addr;
  logic [AW:0]   wr_ptr_q, wr_ptr_d, commit_q, rd_ptr_q;
  logic [WW-1:0] rword;
  mode_e         mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sgf_wctl #(.AW(AW)) u_wctl (
    .clk(clk), .rst_n(rst_int_n), .mode_q(mode_q),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .crc_valid(crc_valid), .crc_pass(crc_pass), .rd_ptr_q(rd_ptr_q),
    .wr_ready(wr_ready), .store_en(store_en), .store_addr(store_addr),
    .wr_ptr_q(wr_ptr_q), .wr_ptr_d(wr_ptr_d), .commit_q(commit_q),
    .in_pkt_q(in_pkt_q), .drop_q(drop_q), .ovf_err(ovf_err)
  );

  sgf_rctl #(.AW(AW), .FILL_W(FILL_W)) u_rctl (
    .clk(clk), .rst_n(rst_int_n), .cfg_mode(cfg_mode), .cfg_fill_level(cfg_fill_level),
    .wr_ptr_q(wr_ptr_q), .wr_ptr_d(wr_ptr_d), .commit_q(commit_q),
    .store_en(store_en), .wr_eop(wr_eop), .in_pkt_q(in_pkt_q), .drop_q(drop_q),
    .rd_ready(rd_ready), .mode_q(mode_q), .rd_valid(rd_valid), .rd_ptr_q(rd_ptr_q)
  );

  sgf_store #(.W(WW), .AW(AW)) u_store (
    .clk(clk), .we(store_en), .waddr(store_addr),
    .wdata({wr_sop, wr_eop, wr_data}),
    .raddr(rd_ptr_q[AW-1:0]), .rdata(rword)
  );

  assign rd_sop  = rword[WW-1];
  assign rd_eop  = rword[WW-2];
  assign rd_data = rword[DATA_W-1:0];
endmodule

// File: tb/tb_stream_gate_fifo.sv
module tb_stream_gate_fifo;
  logic        clk, rst_n;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_fill_level;
  logic        wr_valid, wr_ready, wr_sop, wr_eop;
  logic [15:0] wr_data;
  logic        crc_valid, crc_pass;
  logic        rd_valid, rd_ready, rd_sop, rd_eop, ovf_err;
  logic [15:0] rd_data;
  int checks, fails;
  bit done;

  stream_gate_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fill_level(cfg_fill_level),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .crc_valid(crc_valid), .crc_pass(crc_pass),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_sop(rd_sop), .rd_eop(rd_eop), .ovf_err(ovf_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input bit s, input bit e);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
  endtask

  task automatic pop_exp(input logic [15:0] d, input bit s, input bit e, input string tag);
    @(negedge clk);
    rd_ready = 1'b1;
    #1;
    for (int n = 0; n < 20 && !rd_valid; n++) begin @(negedge clk); #1; end
    chk(rd_valid && rd_data == d && rd_sop == s && rd_eop == e, tag,
        {13'd0, rd_valid, rd_sop, rd_eop, rd_data}, {13'd0, 1'b1, s, e, d});
    @(posedge clk); #1;
    rd_ready = 1'b0;
  endtask

  task automatic peek_valid(input bit exp, input string tag);
    @(negedge clk); #1;
    chk(rd_valid == exp, tag, {31'd0, rd_valid}, {31'd0, exp});
  endtask

  task automatic crc(input bit p);
    @(negedge clk);
    crc_valid = 1'b1; crc_pass = p;
    @(posedge clk); #1;
    crc_valid = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_mode = m;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R12 rd_valid", {31'd0, rd_valid}, 0);
    chk(wr_ready == 1'b1, "R12 wr_ready", {31'd0, wr_ready}, 1);
    chk(ovf_err == 1'b0, "R12 ovf_err", {31'd0, ovf_err}, 0);
  endtask

  task automatic t_short;
    cfg_fill_level = 16'd8;
    set_mode(2'b10);
    push(16'h0011, 1, 0);
    peek_valid(1, "R7 R8 short immediate");
    push(16'h0012, 0, 0);
    crc(1'b0);
    push(16'h0013, 0, 1);
    pop_exp(16'h0011, 1, 0, "R11 first word flags");
    pop_exp(16'h0012, 0, 0, "R7 word kept after fail strobe");
    pop_exp(16'h0013, 0, 1, "R11 last word flags");
    set_mode(2'b11);
    push(16'h0021, 1, 1);
    peek_valid(1, "R1 code 11 is short");
    pop_exp(16'h0021, 1, 1, "R1 code 11 data");
  endtask

  task automatic t_line_pass;
    cfg_fill_level = 16'd1;
    set_mode(2'b00);
    push(16'h0031, 1, 0);
    @(negedge clk); cfg_mode = 2'b10;
    repeat (3) @(posedge clk);
    peek_valid(0, "R1 no switch inside packet");
    @(negedge clk); cfg_mode = 2'b00;
    push(16'h0032, 0, 0);
    push(16'h0033, 0, 1);
    repeat (3) @(posedge clk);
    peek_valid(0, "R2 R8 held before CRC");
    crc(1'b1);
    peek_valid(1, "R2 released after pass");
    pop_exp(16'h0031, 1, 0, "R2 word0");
    pop_exp(16'h0032, 0, 0, "R2 word1");
    pop_exp(16'h0033, 0, 1, "R2 word2");
  endtask

  task automatic t_line_fail;
    push(16'h0041, 1, 0);
    push(16'h0042, 0, 1);
    crc(1'b0);
    peek_valid(0, "R3 failed packet invisible");
    push(16'h0051, 1, 0);
    push(16'h0052, 0, 1);
    crc(1'b1);
    pop_exp(16'h0051, 1, 0, "R3 next packet word0");
    pop_exp(16'h0052, 0, 1, "R3 next packet word1");
    peek_valid(0, "R3 nothing left");
  endtask

  task automatic t_fill;
    cfg_fill_level = 16'd4;
    set_mode(2'b01);
    push(16'h0061, 1, 0);
    push(16'h0062, 0, 0);
    push(16'h0063, 0, 0);
    peek_valid(0, "R4 held below level");
    push(16'h0064, 0, 0);
    peek_valid(1, "R4 released at level");
    pop_exp(16'h0061, 1, 0, "R4 word0");
    pop_exp(16'h0062, 0, 0, "R4 word1");
    peek_valid(1, "R6 stays released below level");
    pop_exp(16'h0063, 0, 0, "R6 word2");
    pop_exp(16'h0064, 0, 0, "R6 word3");
    push(16'h0065, 0, 0);
    peek_valid(0, "R6 held again after empty");
    push(16'h0066, 0, 1);
    peek_valid(1, "R5 end flag releases");
    pop_exp(16'h0065, 0, 0, "R5 word0");
    pop_exp(16'h0066, 0, 1, "R5 word1");
  endtask

  task automatic t_backpressure;
    set_mode(2'b10);
    for (int i = 0; i < 16; i++) push(16'h0070 + 16'(i), i == 0, i == 15);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 16'h00EE; #1;
    chk(wr_ready == 1'b0, "R9 ready low when full", {31'd0, wr_ready}, 0);
    wr_valid = 1'b0;
    for (int i = 0; i < 16; i++) pop_exp(16'h0070 + 16'(i), i == 0, i == 15, "R9 order kept");
  endtask

  task automatic t_overflow;
    set_mode(2'b00);
    for (int i = 0; i < 16; i++) push(16'h0080 + 16'(i), i == 0, 0);
    @(negedge clk); #1;
    chk(ovf_err == 1'b0, "R10 no error yet", {31'd0, ovf_err}, 0);
    push(16'h0090, 0, 0);
    push(16'h0091, 0, 1);
    @(negedge clk); #1;
    chk(ovf_err == 1'b1, "R10 error set", {31'd0, ovf_err}, 1);
    peek_valid(0, "R10 dropped packet invisible");
    crc(1'b1);
    peek_valid(0, "R10 strobe ends drop only");
    push(16'h00A1, 1, 0);
    push(16'h00A2, 0, 1);
    crc(1'b1);
    pop_exp(16'h00A1, 1, 0, "R10 recovery word0");
    pop_exp(16'h00A2, 0, 1, "R10 recovery word1");
    @(negedge clk); #1;
    chk(ovf_err == 1'b1, "R10 error sticky", {31'd0, ovf_err}, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; cfg_mode = 2'b10; cfg_fill_level = 16'd0;
    wr_valid = 1'b0; wr_data = '0; wr_sop = 1'b0; wr_eop = 1'b0;
    crc_valid = 1'b0; crc_pass = 1'b0; rd_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_short();
    t_line_pass();
    t_line_fail();
    t_fill();
    t_backpressure();
    t_overflow();
    finish_run();
  end
endmodule